// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into a serial bit stream on a single output line. A character is offered on a valid/ready handshake together with a seven-bit mode word, a bit-rate divisor and a separate multiprocessor flag bit. When the handshake completes, the block captures all of these and sends a whole frame. During the frame it raises a busy flag and holds off the next character.

The frame shape comes from the mode word. In asynchronous mode a frame is a start bit, the data bits least significant first, an optional extra bit and one or two stop bits. The extra bit is either a parity bit or, in multiprocessor format, a copy of the flag input. In clock-synchronous mode only the data bits are sent. The bit time comes from a four-way clock prescaler that divides by 1, 4, 16 or 64. That rate is then divided by 16 and by (divisor + 1).

Top module: `sertx_core`

## Requirements
- R1: After reset, and at any time no frame is in progress, `tx_o` is 1, `busy_o` is 0 and `in_ready` is 1.
- R2: In asynchronous mode (`mode_i[6]`=0), a frame starts with one 0 bit, followed by the data bits least significant first. Every bit lasts exactly P·16·(`div_i`+1) clock cycles.
- R3: With `mode_i[5]`=1 (parity on), `mode_i[4]`=0 and `mode_i[2]`=0, one bit follows the data. It makes the number of 1s across the data and that bit even.
- R4: With `mode_i[5]`=1, `mode_i[4]`=1 and `mode_i[2]`=0, the bit after the data makes that count of 1s odd.
- R5: With `mode_i[5]`=0 and `mode_i[2]`=0, no bit is inserted after the data, whatever the value of `mode_i[4]`.
- R6: `mode_i[3]`=0 appends one stop bit of 1. `mode_i[3]`=1 appends two stop bits of 1.
- R7: With `mode_i[2]`=1 in asynchronous mode, the bit after the data equals `in_mpb`. `mode_i[5]` and `mode_i[4]` have no effect.
- R8: With `mode_i[6]`=1, only the data bits are sent, least significant first, with no start, parity, flag or stop bit. `mode_i[5:2]` have no effect.
- R9: `mode_i[1:0]` = 0, 1, 2 and 3 set the prescale factor P to 1, 4, 16 and 64.
- R10: A character is accepted only while `busy_o` is 0. `busy_o` stays high for exactly (frame bits)·(bit time) cycles. Changes to `mode_i` and `div_i` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | DATA_W | Character to send |
| in_mpb | input | 1 | Value of the multiprocessor flag bit |
| mode_i | input | 7 | [6] synchronous, [5] parity on, [4] odd, [3] two stops, [2] multiprocessor, [1:0] prescale select |
| div_i | input | DIV_W | Bit-rate divisor |
| tx_o | output | 1 | Serial output, idles at 1 |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=4. The narrow divisor keeps the largest test frames short: with a prescale of 64, an eleven-bit frame takes about eleven thousand cycles. Even so, all four prescale settings can be tested within the run, along with divisors above zero. Every combination of mode bits that overrides another can also be run, including parity under multiprocessor format and every field under synchronous mode.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes the mode word layout below is fixed by the top-level port.
package sertx_pkg;
    typedef struct packed {
        logic       sync_mode;   // [6] data bits only
        logic       par_on;      // [5] parity bit present
        logic       par_odd;     // [4] odd rather than even parity
        logic       two_stop;    // [3] two stop bits
        logic       mp_fmt;      // [2] multiprocessor flag bit instead of parity
        logic [1:0] pre_sel;     // [1:0] prescale select
    } mode_t;

    localparam int PRE_W = 6;    // counter width for the largest prescale (64)
endpackage

// File: rtl/sertx_prescaler.sv
// Prescaler: pulses tick once every 1, 4, 16 or 64 enabled cycles.
// Assumes clr is raised when a frame starts, so that the phase restarts.
module sertx_prescaler
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    // Terminal count for each selected ratio.
    always_comb begin
        case (sel)
            2'd0:    lim = PRE_W'(0);
            2'd1:    lim = PRE_W'(3);
            2'd2:    lim = PRE_W'(15);
            default: lim = PRE_W'(63);
        endcase
    end

    assign tick = en && (cnt_q == lim);

    // Count enabled cycles and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (en)        cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sertx_bit_timer.sv
// Bit timer: counts prescaled ticks and flags the last tick of each bit.
// One bit lasts (div+1) * 2**OVS_LOG2 ticks. Assumes div is constant during a frame.
module sertx_bit_timer #(
    parameter int DIV_W    = 8,
    parameter int OVS_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end
);
    localparam int TC_W = DIV_W + OVS_LOG2;

    logic [TC_W-1:0] tc_q;
    logic [TC_W-1:0] tc_max;

    assign tc_max  = {div, {OVS_LOG2{1'b1}}};
    assign bit_end = en && (tc_q == tc_max);

    // Advance on each tick and restart at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  tc_q <= '0;
        else if (en)        tc_q <= bit_end ? '0 : tc_q + 1'b1;
    end
endmodule

// File: rtl/sertx_framer.sv
// Framer: builds the frame, first bit at index 0, and gives its length in bits.
// Unused upper positions are 1, so shifting in ones pads the line to idle.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int NB_W    = 4
) (
    input  logic [DATA_W-1:0]  data,
    input  mode_t              mode,
    input  logic               mpb,
    output logic [FRAME_W-1:0] frame,
    output logic [NB_W-1:0]    nbits
);
    // Arrange the start, data, extra and stop bits according to the mode.
    always_comb begin
        frame = '1;
        if (mode.sync_mode) begin
            frame[DATA_W-1:0] = data;
            nbits = NB_W'(DATA_W);
        end else begin
            frame[0]          = 1'b0;
            frame[DATA_W:1]   = data;
            nbits = NB_W'(DATA_W + 2) + NB_W'(mode.two_stop);
            if (mode.mp_fmt) begin
                frame[DATA_W+1] = mpb;
                nbits = nbits + 1'b1;
            end else if (mode.par_on) begin
                frame[DATA_W+1] = (^data) ^ mode.par_odd;
                nbits = nbits + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sertx_core.sv
// Serial transmitter top: takes one character on the handshake, captures the mode,
// divisor and flag bit, and shifts the frame out at the configured bit rate.
// Assumes a single clock domain and a synchronous active-low reset.
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int OVS_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mpb,
    input  logic [6:0]        mode_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              tx_o,
    output logic              busy_o
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    mode_t              mode_w;
    logic [FRAME_W-1:0] frame_w;
    logic [NB_W-1:0]    nbits_w;
    logic               busy_q;
    logic [FRAME_W-1:0] sh_q;
    logic [NB_W-1:0]    left_q;
    logic [1:0]         cks_q;
    logic [DIV_W-1:0]   div_q;
    logic               load;
    logic               tick;
    logic               bit_end;

    assign mode_w = mode_t'(mode_i);
    assign load   = in_valid && !busy_q;

    sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_framer (
        .data(in_data), .mode(mode_w), .mpb(in_mpb), .frame(frame_w), .nbits(nbits_w)
    );

    sertx_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clr(load), .en(busy_q), .sel(cks_q), .tick(tick)
    );

    sertx_bit_timer #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(load), .en(busy_q && tick), .div(div_q),
        .bit_end(bit_end)
    );

    // Load a frame on handshake and shift one bit out at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
            cks_q  <= '0;
            div_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            sh_q   <= frame_w;
            left_q <= nbits_w;
            cks_q  <= mode_w.pre_sel;
            div_q  <= div_i;
        end else if (bit_end) begin
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == NB_W'(1)) busy_q <= 1'b0;
        end
    end

    assign tx_o     = busy_q ? sh_q[0] : 1'b1;
    assign busy_o   = busy_q;
    assign in_ready = !busy_q;
endmodule

// File: rtl/sertx_check.sv
// Checker for sertx_core: timing properties of the handshake, the line and the prescaler.
module sertx_check (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [6:0] mode_i,
    input logic       tx_o,
    input logic       busy_o,
    input logic       tick,
    input logic       bit_end,
    input logic [1:0] cks_q
);
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !mode_i[6]) |=> (busy_o && !tx_o));

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_end) |=> $stable(tx_o));

    p_base_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cks_q == 2'd0) |-> tick);

    p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !in_ready);
endmodule

bind sertx_core sertx_check u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_i(mode_i), .tx_o(tx_o), .busy_o(busy_o), .tick(tick),
    .bit_end(bit_end), .cks_q(cks_q)
);

// File: tb/sertx_core_test.sv
module sertx_core_test;
    localparam int DW = 8;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_mpb = 1'b0;
    logic [6:0]    mode_i = '0;
    logic [VW-1:0] div_i = '0;
    logic          tx_o;
    logic          busy_o;

    int tests = 0;
    int fails = 0;
    int sent = 0;
    int seen = 0;

    typedef struct {
        logic [15:0] bits;
        int          n;
        int          len;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    sertx_core #(.DATA_W(DW), .DIV_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mpb(in_mpb), .mode_i(mode_i), .div_i(div_i),
        .tx_o(tx_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: compute the expected frame from the requirements, queue it, then hand over the character.
    task automatic send(input logic [7:0] d, input logic [6:0] m, input logic [VW-1:0] dv,
                        input logic mpb, input string req);
        exp_t e;
        int ones;
        e.bits = '1; e.n = 0; e.req = req;
        if (m[6]) begin
            for (int i = 0; i < 8; i++) begin e.bits[e.n] = d[i]; e.n++; end
        end else begin
            e.bits[e.n] = 1'b0; e.n++;
            ones = 0;
            for (int i = 0; i < 8; i++) begin e.bits[e.n] = d[i]; e.n++; ones += int'(d[i]); end
            if (m[2]) begin e.bits[e.n] = mpb; e.n++; end
            else if (m[5]) begin e.bits[e.n] = ((ones % 2) == 1) ^ m[4]; e.n++; end
            e.bits[e.n] = 1'b1; e.n++;
            if (m[3]) begin e.bits[e.n] = 1'b1; e.n++; end
        end
        e.len = (1 << (2 * int'(m[1:0]))) * 16 * (int'(dv) + 1);
        do @(negedge clk); while (!in_ready);
        q.push_back(e);
        sent++;
        in_data = d; mode_i = m; div_i = dv; in_mpb = mpb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: on each frame start, pop the expected frame and sample every bit mid-way.
    initial begin
        forever begin
            exp_t e;
            int k;
            @(posedge busy_o);
            if (q.size() == 0) begin
                check("R10", "unexpected frame", 1, 0);
                continue;
            end
            e = q.pop_front();
            k = 0;
            forever begin
                @(negedge clk);
                if (!busy_o) break;
                if (k % e.len == e.len / 2)
                    check(e.req, $sformatf("bit %0d", k / e.len), int'(tx_o),
                          (k / e.len < 16) ? int'(e.bits[k / e.len]) : 1);
                k++;
            end
            check("R10", {e.req, " busy length"}, k, e.n * e.len);
            check("R1", "idle line after frame", int'(tx_o), 1);
            seen++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset tx", int'(tx_o), 1);
        check("R1", "reset busy", int'(busy_o), 0);
        check("R1", "reset ready", int'(in_ready), 1);

        send(8'hA5, 7'b0000000, 4'd0, 1'b0, "R2");
        send(8'h07, 7'b0100000, 4'd1, 1'b0, "R3");
        send(8'h07, 7'b0110000, 4'd1, 1'b0, "R4");
        send(8'h3C, 7'b0010000, 4'd0, 1'b0, "R5");
        send(8'h81, 7'b0001000, 4'd0, 1'b0, "R6");
        send(8'h81, 7'b0111000, 4'd2, 1'b0, "R6");
        send(8'h07, 7'b0110100, 4'd0, 1'b1, "R7");
        send(8'h06, 7'b0100100, 4'd0, 1'b0, "R7");
        send(8'h96, 7'b1111100, 4'd0, 1'b1, "R8");
        send(8'h5A, 7'b1000000, 4'd1, 1'b0, "R8");
        send(8'hC3, 7'b0000001, 4'd0, 1'b0, "R9");
        send(8'h3E, 7'b0100010, 4'd0, 1'b0, "R9");
        send(8'h69, 7'b0000011, 4'd0, 1'b0, "R9");

        // R10: change mode and divisor mid-frame, offer nothing; check ready is held low.
        send(8'hF0, 7'b0100000, 4'd0, 1'b0, "R10");
        repeat (20) @(negedge clk);
        mode_i = 7'b1111111; div_i = 4'hF; in_mpb = 1'b1;
        check("R10", "ready while busy", int'(in_ready), 0);
        send(8'h01, 7'b0000000, 4'd0, 1'b0, "R10");

        while (seen < sent || busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10", "frames seen", seen, sent);
        check("R1", "final ready", int'(in_ready), 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule